// File: doc/BRIEF.md
# Video Processor Control Port Command Decoder

This block sits behind the control and data ports of a video processor. Every 16-bit word written to the control port is either an immediate write into a file of 24 eight-bit configuration registers, or one half of a two-word command. A two-word command loads a 16-bit access address and a 6-bit access code. A pending flag tracks whether the first half of a command has arrived and the second is still awaited.

Data-port accesses use the current code to choose a target: video RAM, colour RAM or scroll RAM. The block issues a one-cycle request to that memory. It applies the byte swap for odd video-RAM writes and packs colour words into 9-bit entries. After every data access it advances the address by the step held in configuration register 15.

The memories and the renderer are outside the block. The block only produces their request strobes, addresses and write data, and exposes the register file through a read index.

Top module: `cmdport_top`

## Requirements
- R1: After reset the address, code, pending flag and all 24 registers are zero, and no memory request is active.
- R2: A control word that arrives while nothing is pending and has bits 15:14 equal to 2'b10 writes bits 7:0 into register number bits 12:8. It leaves the pending flag clear, sets the address to {latched high pair, word[13:0]} and sets code[1:0] to 2'b10.
- R3: Any other control word that arrives while nothing is pending sets the pending flag, sets the address to {latched high pair, word[13:0]} and sets code[1:0] to word[15:14].
- R4: A control word that arrives while pending clears the flag and stores word[1:0] both as address bits 15:14 and as the latched high pair used by later first words. It loads code[5:2] from word[7:4] and leaves address bits 13:0 and code[1:0] unchanged.
- R5: A register write to a number above 10 is dropped unless bit 2 of register 1 is set. Numbers 24 to 31 are always dropped.
- R6: A status read, data read or data write clears the pending flag. If a control write arrives in the same cycle, it alone takes effect and the data and status strobes are ignored. A data write outranks a data read.
- R7: A data write with code[3:0] = 1 requests a video-RAM write, 3 a colour-RAM write and 5 a scroll-RAM write. Any other code requests nothing. Requests are registered and are high for exactly the cycle after the strobe.
- R8: A data read with code[3:0] = 0 requests a video-RAM read, 8 a colour-RAM read and 4 a scroll-RAM read. Any other code requests nothing.
- R9: Every accepted data read or write, whatever its target, adds register 15 to the address, modulo 2^16.
- R10: A video-RAM request presents the address with bit 0 cleared. A write whose address bit 0 is set swaps the two bytes of the data word.
- R11: A colour-RAM write presents the 9-bit entry {d[11:9], d[7:5], d[3:1]}. Colour and scroll requests use address bits 6:1 as the 6-bit entry index, and scroll writes pass the full 16-bit word.
- R12: The register read port returns register number reg_rd_idx combinationally, and zero for indices 24 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control-port write strobe |
| ctrl_wdata | input | 16 | Control-port write word |
| stat_re | input | 1 | Status-port read strobe |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port write word |
| data_re | input | 1 | Data-port read strobe |
| reg_rd_idx | input | 5 | Register file read index |
| reg_rd_val | output | 8 | Register value at reg_rd_idx |
| cur_addr | output | 16 | Current access address |
| cur_code | output | 6 | Current access code |
| cmd_pending | output | 1 | First half of a command received |
| vram_we | output | 1 | Video-RAM write request |
| vram_re | output | 1 | Video-RAM read request |
| vram_addr | output | 16 | Video-RAM word-aligned byte address |
| vram_wdata | output | 16 | Video-RAM write word |
| cram_we | output | 1 | Colour-RAM write request |
| cram_re | output | 1 | Colour-RAM read request |
| cram_addr | output | 6 | Colour-RAM entry index |
| cram_wdata | output | 9 | Packed colour entry |
| vsram_we | output | 1 | Scroll-RAM write request |
| vsram_re | output | 1 | Scroll-RAM read request |
| vsram_addr | output | 6 | Scroll-RAM entry index |
| vsram_wdata | output | 16 | Scroll-RAM write word |

## Verification
A pending flag stuck high or low causes the next control word to take the wrong half of the protocol. That shows on cur_code and cur_addr one cycle later, and a wrongly latched high address pair shows on the following first word. A bad increment or code decode shows on the very next memory request, as a wrong address, a wrong target or a missing strobe. A gating fault in the register file is only visible through the read port, so every gated write is followed at once by a read-back of the targeted register.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_VRAM  = 2'd1,
      TGT_CRAM  = 2'd2,
      TGT_VSRAM = 2'd3
   } tgt_e;

   // code[3:0] values that select a memory, per direction
   localparam logic [3:0] CODE_VRAM_WR  = 4'h1;
   localparam logic [3:0] CODE_CRAM_WR  = 4'h3;
   localparam logic [3:0] CODE_VSRAM_WR = 4'h5;
   localparam logic [3:0] CODE_VRAM_RD  = 4'h0;
   localparam logic [3:0] CODE_CRAM_RD  = 4'h8;
   localparam logic [3:0] CODE_VSRAM_RD = 4'h4;

   // control word high pair that marks an immediate register write
   localparam logic [1:0] REGWR_TAG = 2'b10;

   function automatic tgt_e target_of(input logic [3:0] sel, input logic is_wr);
      tgt_e t;
      t = TGT_NONE;
      if (is_wr) begin
         case (sel)
            CODE_VRAM_WR:  t = TGT_VRAM;
            CODE_CRAM_WR:  t = TGT_CRAM;
            CODE_VSRAM_WR: t = TGT_VSRAM;
            default:       t = TGT_NONE;
         endcase
      end else begin
         case (sel)
            CODE_VRAM_RD:  t = TGT_VRAM;
            CODE_CRAM_RD:  t = TGT_CRAM;
            CODE_VSRAM_RD: t = TGT_VSRAM;
            default:       t = TGT_NONE;
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode
   import cmdport_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CODE_W = 6,
   parameter int IDX_W  = 5,
   parameter int REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [15:0]       ctrl_wdata,
   input  logic              clr_pend,
   input  logic              step,
   input  logic [REG_W-1:0]  inc,
   output logic [ADDR_W-1:0] addr,
   output logic [CODE_W-1:0] code,
   output logic              pending,
   output logic              rw_en,
   output logic [IDX_W-1:0]  rw_idx,
   output logic [REG_W-1:0]  rw_val
);
   localparam int LO_W = ADDR_W - 2;

   if (ADDR_W != 16) begin : g_bad_addr
      $error("cmdport_decode: ADDR_W must be 16");
   end
   if (CODE_W != 6) begin : g_bad_code
      $error("cmdport_decode: CODE_W must be 6");
   end
   if (IDX_W > 5 || REG_W > 8) begin : g_bad_reg
      $error("cmdport_decode: register fields exceed the word layout");
   end

   logic [1:0] hi_latch;
   logic       is_regwr;

   assign is_regwr = !pending && (ctrl_wdata[15:14] == REGWR_TAG);
   assign rw_en    = ctrl_we && is_regwr;
   assign rw_idx   = ctrl_wdata[8 +: IDX_W];
   assign rw_val   = ctrl_wdata[REG_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr     <= '0;
         code     <= '0;
         pending  <= 1'b0;
         hi_latch <= 2'b00;
      end else if (ctrl_we) begin
         if (!pending) begin
            pending   <= !is_regwr;
            addr      <= {hi_latch, ctrl_wdata[LO_W-1:0]};
            code[1:0] <= ctrl_wdata[15:14];
         end else begin
            pending     <= 1'b0;
            hi_latch    <= ctrl_wdata[1:0];
            addr        <= {ctrl_wdata[1:0], addr[LO_W-1:0]};
            code[5:2]   <= ctrl_wdata[7:4];
         end
      end else begin
         if (clr_pend) pending <= 1'b0;
         if (step)     addr    <= addr + ADDR_W'(inc);
      end
   end

   p_first_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we && !pending && ctrl_wdata[15:14] != REGWR_TAG |=> pending);

   p_second_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we && pending |=> !pending && addr[ADDR_W-1 -: 2] == $past(ctrl_wdata[1:0]));

   p_access_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we && clr_pend |=> !pending);

   p_step_adds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we && step |=> addr == ADDR_W'($past(addr) + ADDR_W'($past(inc))));

endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs #(
   parameter int NUM_REGS = 24,
   parameter int REG_W    = 8,
   parameter int IDX_W    = 5,
   parameter int GATE_IDX = 10,
   parameter int MODE_REG = 1,
   parameter int MODE_BIT = 2,
   parameter int INC_REG  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [REG_W-1:0] rd_val,
   output logic [REG_W-1:0] inc_val
);
   if (NUM_REGS > (1 << IDX_W)) begin : g_bad_depth
      $error("cmdport_regs: NUM_REGS does not fit IDX_W");
   end
   if (MODE_REG >= NUM_REGS || INC_REG >= NUM_REGS || MODE_BIT >= REG_W) begin : g_bad_sel
      $error("cmdport_regs: special register outside the file");
   end

   logic [NUM_REGS-1:0][REG_W-1:0] file_q;
   logic                           mode_on;

   assign mode_on = file_q[MODE_REG][MODE_BIT];
   assign inc_val = file_q[INC_REG];

   for (genvar e = 0; e < NUM_REGS; e++) begin : g_ent
      logic [REG_W-1:0] q;
      logic             hit;
      if (e > GATE_IDX) begin : g_gated
         assign hit = wr_en && mode_on && (wr_idx == IDX_W'(e));
      end else begin : g_open
         assign hit = wr_en && (wr_idx == IDX_W'(e));
      end
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= wr_val;
      end
      assign file_q[e] = q;
   end

   always_comb begin
      rd_val = '0;
      for (int e = 0; e < NUM_REGS; e++) begin
         if (rd_idx == IDX_W'(e)) rd_val = file_q[e];
      end
   end

   p_gated_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_idx > IDX_W'(GATE_IDX) && !mode_on |=> $stable(file_q));

   p_beyond_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_idx >= IDX_W'(NUM_REGS) |=> $stable(file_q));

endmodule

// File: rtl/cmdport_route.sv
module cmdport_route
   import cmdport_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CODE_W = 6,
   parameter int CH_W   = 3,
   parameter int TBL_AW = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_we,
   input  logic                acc_re,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [CODE_W-1:0]   code,
   input  logic [ADDR_W-1:0]   addr,
   output logic                vram_we,
   output logic                vram_re,
   output logic [ADDR_W-1:0]   vram_addr,
   output logic [DATA_W-1:0]   vram_wdata,
   output logic                cram_we,
   output logic                cram_re,
   output logic [TBL_AW-1:0]   cram_addr,
   output logic [3*CH_W-1:0]   cram_wdata,
   output logic                vsram_we,
   output logic                vsram_re,
   output logic [TBL_AW-1:0]   vsram_addr,
   output logic [DATA_W-1:0]   vsram_wdata
);
   localparam int HALF = DATA_W / 2;
   localparam int PK_W = 3 * CH_W;

   if (CH_W < 1 || CH_W > 3 || DATA_W != 16) begin : g_bad_colour
      $error("cmdport_route: colour channel field must be 1 to 3 bits of a 16-bit word");
   end
   if (TBL_AW + 1 > ADDR_W) begin : g_bad_tbl
      $error("cmdport_route: table index wider than address");
   end

   logic [PK_W-1:0]   packed_col;
   logic [DATA_W-1:0] swapped;
   tgt_e              tgt;
   logic              any;

   // each channel sits in a nibble, its top CH_W bits above bit 0 of the nibble
   for (genvar c = 0; c < 3; c++) begin : g_chan
      assign packed_col[c*CH_W +: CH_W] = wdata[4*c+1 +: CH_W];
   end

   assign swapped = addr[0] ? {wdata[HALF-1:0], wdata[DATA_W-1:HALF]} : wdata;
   assign any     = acc_we || acc_re;
   assign tgt     = target_of(code[3:0], acc_we);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vram_we     <= 1'b0;
         vram_re     <= 1'b0;
         cram_we     <= 1'b0;
         cram_re     <= 1'b0;
         vsram_we    <= 1'b0;
         vsram_re    <= 1'b0;
         vram_addr   <= '0;
         vram_wdata  <= '0;
         cram_addr   <= '0;
         cram_wdata  <= '0;
         vsram_addr  <= '0;
         vsram_wdata <= '0;
      end else begin
         vram_we  <= any && acc_we  && tgt == TGT_VRAM;
         vram_re  <= any && !acc_we && tgt == TGT_VRAM;
         cram_we  <= any && acc_we  && tgt == TGT_CRAM;
         cram_re  <= any && !acc_we && tgt == TGT_CRAM;
         vsram_we <= any && acc_we  && tgt == TGT_VSRAM;
         vsram_re <= any && !acc_we && tgt == TGT_VSRAM;
         if (any) begin
            vram_addr   <= {addr[ADDR_W-1:1], 1'b0};
            vram_wdata  <= swapped;
            cram_addr   <= addr[TBL_AW:1];
            cram_wdata  <= packed_col;
            vsram_addr  <= addr[TBL_AW:1];
            vsram_wdata <= wdata;
         end
      end
   end

   p_vram_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we && code[3:0] == CODE_VRAM_WR |=> vram_we && !vram_addr[0]);

   p_cram_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_re && !acc_we && code[3:0] == CODE_CRAM_RD |=> cram_re);

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_we && !acc_re |=> !(vram_we || vram_re || cram_we || cram_re || vsram_we || vsram_re));

endmodule

// File: rtl/cmdport_top.sv
module cmdport_top #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int CODE_W   = 6,
   parameter int REG_W    = 8,
   parameter int NUM_REGS = 24,
   parameter int IDX_W    = 5,
   parameter int GATE_IDX = 10,
   parameter int MODE_REG = 1,
   parameter int MODE_BIT = 2,
   parameter int INC_REG  = 15,
   parameter int CH_W     = 3,
   parameter int TBL_AW   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_we,
   input  logic [15:0]         ctrl_wdata,
   input  logic                stat_re,
   input  logic                data_we,
   input  logic [DATA_W-1:0]   data_wdata,
   input  logic                data_re,
   input  logic [IDX_W-1:0]    reg_rd_idx,
   output logic [REG_W-1:0]    reg_rd_val,
   output logic [ADDR_W-1:0]   cur_addr,
   output logic [CODE_W-1:0]   cur_code,
   output logic                cmd_pending,
   output logic                vram_we,
   output logic                vram_re,
   output logic [ADDR_W-1:0]   vram_addr,
   output logic [DATA_W-1:0]   vram_wdata,
   output logic                cram_we,
   output logic                cram_re,
   output logic [TBL_AW-1:0]   cram_addr,
   output logic [3*CH_W-1:0]   cram_wdata,
   output logic                vsram_we,
   output logic                vsram_re,
   output logic [TBL_AW-1:0]   vsram_addr,
   output logic [DATA_W-1:0]   vsram_wdata
);
   // control writes outrank every other strobe; data write outranks data read
   logic             acc_we, acc_re, clr_pend, step;
   logic             rw_en;
   logic [IDX_W-1:0] rw_idx;
   logic [REG_W-1:0] rw_val;
   logic [REG_W-1:0] inc_val;

   assign acc_we   = data_we && !ctrl_we;
   assign acc_re   = data_re && !ctrl_we && !data_we;
   assign step     = acc_we || acc_re;
   assign clr_pend = step || (stat_re && !ctrl_we);

   cmdport_decode #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W),
      .IDX_W  (IDX_W),
      .REG_W  (REG_W)
   ) i_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .clr_pend   (clr_pend),
      .step       (step),
      .inc        (inc_val),
      .addr       (cur_addr),
      .code       (cur_code),
      .pending    (cmd_pending),
      .rw_en      (rw_en),
      .rw_idx     (rw_idx),
      .rw_val     (rw_val)
   );

   cmdport_regs #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .IDX_W    (IDX_W),
      .GATE_IDX (GATE_IDX),
      .MODE_REG (MODE_REG),
      .MODE_BIT (MODE_BIT),
      .INC_REG  (INC_REG)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rw_en),
      .wr_idx  (rw_idx),
      .wr_val  (rw_val),
      .rd_idx  (reg_rd_idx),
      .rd_val  (reg_rd_val),
      .inc_val (inc_val)
   );

   cmdport_route #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CODE_W (CODE_W),
      .CH_W   (CH_W),
      .TBL_AW (TBL_AW)
   ) i_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_we      (acc_we),
      .acc_re      (acc_re),
      .wdata       (data_wdata),
      .code        (cur_code),
      .addr        (cur_addr),
      .vram_we     (vram_we),
      .vram_re     (vram_re),
      .vram_addr   (vram_addr),
      .vram_wdata  (vram_wdata),
      .cram_we     (cram_we),
      .cram_re     (cram_re),
      .cram_addr   (cram_addr),
      .cram_wdata  (cram_wdata),
      .vsram_we    (vsram_we),
      .vsram_re    (vsram_re),
      .vsram_addr  (vsram_addr),
      .vsram_wdata (vsram_wdata)
   );

   p_ctrl_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we && data_we |=> !(vram_we || cram_we || vsram_we || vram_re || cram_re || vsram_re));

endmodule

// File: tb/test_cmdport_top.sv
module test_cmdport_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ctrl_we, stat_re, data_we, data_re;
   logic [15:0] ctrl_wdata, data_wdata;
   logic [4:0]  reg_rd_idx;
   logic [7:0]  reg_rd_val;
   logic [15:0] cur_addr;
   logic [5:0]  cur_code;
   logic        cmd_pending;
   logic        vram_we, vram_re, cram_we, cram_re, vsram_we, vsram_re;
   logic [15:0] vram_addr, vram_wdata, vsram_wdata;
   logic [5:0]  cram_addr, vsram_addr;
   logic [8:0]  cram_wdata;

   always #2 clk = ~clk;

   cmdport_top i_cmdport_top (
      .clk (clk), .rst_n (rst_n),
      .ctrl_we (ctrl_we), .ctrl_wdata (ctrl_wdata), .stat_re (stat_re),
      .data_we (data_we), .data_wdata (data_wdata), .data_re (data_re),
      .reg_rd_idx (reg_rd_idx), .reg_rd_val (reg_rd_val),
      .cur_addr (cur_addr), .cur_code (cur_code), .cmd_pending (cmd_pending),
      .vram_we (vram_we), .vram_re (vram_re), .vram_addr (vram_addr), .vram_wdata (vram_wdata),
      .cram_we (cram_we), .cram_re (cram_re), .cram_addr (cram_addr), .cram_wdata (cram_wdata),
      .vsram_we (vsram_we), .vsram_re (vsram_re), .vsram_addr (vsram_addr), .vsram_wdata (vsram_wdata)
   );

   int unsigned n_chk = 0;
   int unsigned n_err = 0;
   bit          done  = 1'b0;

   // reference model
   logic [15:0] m_addr;
   logic [5:0]  m_code;
   logic        m_pend;
   logic [1:0]  m_hi;
   logic [7:0]  m_regs [32];
   // expected request bits {vram_we, vram_re, cram_we, cram_re, vsram_we, vsram_re}
   logic [5:0]  e_req;
   logic [15:0] e_vaddr, e_vdata, e_sdata;
   logic [5:0]  e_caddr, e_saddr;
   logic [8:0]  e_cdata;

   function automatic logic [8:0] pack_col(input logic [15:0] d);
      return {d[11:9], d[7:5], d[3:1]};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_reg(input int idx, input string tag);
      reg_rd_idx = 5'(idx);
      #0.5;
      chk(tag, $sformatf("reg[%0d]", idx), {24'h0, reg_rd_val}, {24'h0, m_regs[idx]});
   endtask

   task automatic check_all(input string stag, input string rtag);
      chk(stag, "addr", {16'h0, cur_addr}, {16'h0, m_addr});
      chk(stag, "code", {26'h0, cur_code}, {26'h0, m_code});
      chk(stag, "pending", {31'h0, cmd_pending}, {31'h0, m_pend});
      chk(rtag, "requests", {26'h0, vram_we, vram_re, cram_we, cram_re, vsram_we, vsram_re}, {26'h0, e_req});
      if (e_req[5] || e_req[4]) chk(rtag, "vram_addr", {16'h0, vram_addr}, {16'h0, e_vaddr});
      if (e_req[5]) chk(rtag, "vram_wdata", {16'h0, vram_wdata}, {16'h0, e_vdata});
      if (e_req[3] || e_req[2]) chk(rtag, "cram_addr", {26'h0, cram_addr}, {26'h0, e_caddr});
      if (e_req[3]) chk(rtag, "cram_wdata", {23'h0, cram_wdata}, {23'h0, e_cdata});
      if (e_req[1] || e_req[0]) chk(rtag, "vsram_addr", {26'h0, vsram_addr}, {26'h0, e_saddr});
      if (e_req[1]) chk(rtag, "vsram_wdata", {16'h0, vsram_wdata}, {16'h0, e_sdata});
      check_reg(int'($urandom % 32), "R12");
   endtask

   task automatic idle_strobes();
      ctrl_we = 1'b0; stat_re = 1'b0; data_we = 1'b0; data_re = 1'b0;
   endtask

   task automatic ctrl_op(input logic [15:0] d, input bit both = 1'b0);
      string t;
      int    idx;
      e_req = '0;
      if (!m_pend) begin
         if (d[15:14] == 2'b10) begin
            idx = int'(d[12:8]);
            if (idx >= 24 || (idx > 10 && !m_regs[1][2])) t = "R5";
            else begin
               t = "R2";
               m_regs[idx] = d[7:0];
            end
         end else begin
            t = "R3";
            m_pend = 1'b1;
         end
         m_addr = {m_hi, d[13:0]};
         m_code[1:0] = d[15:14];
      end else begin
         t = "R4";
         m_pend = 1'b0;
         m_hi = d[1:0];
         m_addr[15:14] = d[1:0];
         m_code[5:2] = d[7:4];
      end
      if (both) t = "R6";
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = d;
      if (both) begin
         data_we = 1'b1; data_re = 1'b1; stat_re = 1'b1;
         data_wdata = 16'($urandom);
      end
      @(negedge clk);
      idle_strobes();
      check_all(t, t);
   endtask

   task automatic data_wr(input logic [15:0] d);
      string t;
      t = "R7";
      e_req = '0;
      case (m_code[3:0])
         4'h1: begin
            e_req[5] = 1'b1; t = "R10";
            e_vaddr = {m_addr[15:1], 1'b0};
            e_vdata = m_addr[0] ? {d[7:0], d[15:8]} : d;
         end
         4'h3: begin
            e_req[3] = 1'b1; t = "R11";
            e_caddr = m_addr[6:1];
            e_cdata = pack_col(d);
         end
         4'h5: begin
            e_req[1] = 1'b1; t = "R11";
            e_saddr = m_addr[6:1];
            e_sdata = d;
         end
         default: ;
      endcase
      m_pend = 1'b0;
      m_addr = m_addr + {8'h00, m_regs[15]};
      @(negedge clk);
      data_we = 1'b1;
      data_wdata = d;
      @(negedge clk);
      idle_strobes();
      check_all("R9", t);
   endtask

   task automatic data_rd();
      e_req = '0;
      case (m_code[3:0])
         4'h0: begin e_req[4] = 1'b1; e_vaddr = {m_addr[15:1], 1'b0}; end
         4'h8: begin e_req[2] = 1'b1; e_caddr = m_addr[6:1]; end
         4'h4: begin e_req[0] = 1'b1; e_saddr = m_addr[6:1]; end
         default: ;
      endcase
      m_pend = 1'b0;
      m_addr = m_addr + {8'h00, m_regs[15]};
      @(negedge clk);
      data_re = 1'b1;
      @(negedge clk);
      idle_strobes();
      check_all("R9", "R8");
   endtask

   task automatic stat_rd();
      e_req = '0;
      m_pend = 1'b0;
      @(negedge clk);
      stat_re = 1'b1;
      @(negedge clk);
      idle_strobes();
      check_all("R6", "R6");
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(4.0 * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4099));
      rst_n = 1'b0;
      idle_strobes();
      ctrl_wdata = '0; data_wdata = '0; reg_rd_idx = '0;
      m_addr = '0; m_code = '0; m_pend = 1'b0; m_hi = 2'b00; e_req = '0;
      for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_all("R1", "R1");
      for (int i = 0; i < 32; i++) check_reg(i, "R1");

      // R2: immediate write of the address step
      ctrl_op(16'h8F02);
      check_reg(15, "R2");
      // R5: gating by mode bit, and out-of-file numbers
      ctrl_op(16'h8B55);
      check_reg(11, "R5");
      ctrl_op(16'h8A33);
      check_reg(10, "R5");
      ctrl_op(16'h8104);
      ctrl_op(16'h8B55);
      check_reg(11, "R5");
      ctrl_op(16'h9E77);
      check_reg(30, "R5");

      // R3/R4/R10: two-word video-RAM write at an odd address
      ctrl_op(16'h4001);
      ctrl_op(16'h0002);
      data_wr(16'hABCD);
      // R4: latched high pair reused by a later first word; R6 status read clears
      ctrl_op(16'h4010);
      stat_rd();
      data_wr(16'h1234);

      // R11: colour RAM writes
      ctrl_op(16'hC002);
      ctrl_op(16'h0000);
      data_wr(16'h0EEE);
      data_wr(16'h0A52);
      // R11: scroll RAM write
      ctrl_op(16'h4000);
      ctrl_op(16'h0010);
      data_wr(16'hBEEF);
      // R8: reads of each memory
      ctrl_op(16'h0000);
      ctrl_op(16'h0020);
      data_rd();
      data_rd();
      ctrl_op(16'h0004);
      ctrl_op(16'h0010);
      data_rd();
      ctrl_op(16'h0006);
      ctrl_op(16'h0000);
      data_rd();
      // R7: unused code produces no request
      ctrl_op(16'hC000);
      ctrl_op(16'h0070);
      data_wr(16'h5555);

      // R6: control write colliding with every other strobe
      ctrl_op(16'h4000, 1'b1);
      // R6: data read clears a half-received command
      data_rd();
      ctrl_op(16'h4000);
      data_rd();
      // R9: step of 0xFF wraps the address
      ctrl_op(16'h8FFF);
      ctrl_op(16'h7FF0);
      ctrl_op(16'h0003);
      data_wr(16'h0F0F);
      data_wr(16'hF0F0);

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 3) ctrl_op({3'b100, 5'($urandom % 26), 8'($urandom)});
         else if (r < 6) ctrl_op(16'($urandom));
         else if (r < 8) data_wr(16'($urandom));
         else if (r < 9) data_rd();
         else stat_rd();
      end

      @(negedge clk);
      for (int i = 0; i < 32; i++) check_reg(i, "R12");
      finish_run();
   end

endmodule